// File: doc/BRIEF.md
# Triple Match-Compare Timer Peripheral

The block holds three independent 32-bit timers behind a simple two-phase register bus with a setup cycle and an access cycle. Each timer has a counter, a reload value and two compare values. A counter steps either on every bus clock or on rising edges of a shared external tick, which passes through a two-flop synchronizer. It counts up or down. When it runs past its end value, it reloads from its reload register and records an overflow event. Compare events are recorded when a step lands the counter exactly on one of its compare values.

Three registers are shared by all timers: a packed control word, a sticky event status word that is cleared by writing ones, and an event mask. Each timer drives its own registered interrupt line, which is the OR of its unmasked status bits gated by its interrupt-enable bit. Software builds a periodic tick by writing the all-ones value minus (P−1) to both the counter and the reload register, which gives an overflow every P steps. It builds a one-shot by setting compare 1 to the current count plus a delta.

Top module: `tri_cmp_timer`

## Requirements
- R1: After reset every register reads 0 and all three interrupt outputs are low.
- R2: Timer n (1..3) has its registers at 0x10·(n−1): counter +0x0, reload +0x4, compare 1 +0x8, compare 2 +0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Reads return the value written. Read data is captured in the setup cycle and is valid during the access cycle.
- R3: A write to a counter sets it directly, and a bus write takes priority over a step in the same cycle. A timer whose enable bit is clear holds its count.
- R4: Control bits for timer n: bit 3(n−1) is enable, bit 3(n−1)+1 is clock select, bit 3(n−1)+2 is interrupt enable, and bit 8+n is direction (0 = up). With select 0, an enabled timer advances once per bus clock.
- R5: When counting up, a step from 0xFFFFFFFF loads the reload value and sets the overflow status bit. With counter = reload = 0xFFFFFFFF−(P−1), overflow occurs every P steps.
- R6: When counting down, a step from 0 loads the reload value and sets the overflow status bit.
- R7: Status and mask bits for timer n: bit 3(n−1) is compare 1, bit 3(n−1)+1 is compare 2, bit 3(n−1)+2 is overflow. A step whose new count equals a compare value sets the matching bit.
- R8: Status bits are sticky. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the bit set.
- R9: The interrupt for timer n is high when that timer's interrupt-enable bit is set and one of its status bits is set with the mask bit clear (1 = blocked). Masking does not change the status read-back. The output is registered.
- R10: With select 1, a timer advances once per rising edge of the external tick, and the bus clock does not advance it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| ext_tick | input | 1 | Asynchronous external count tick |
| irq | output | 3 | Per-timer interrupt, bit n−1 for timer n |

## Verification
The assertions assume that every bus transfer is a proper pair of cycles: a setup cycle with select high and penable low, then one access cycle. They also assume that only word-aligned addresses are used and that the external tick may change at any time. The stimulus tasks always issue that two-cycle pattern on aligned offsets. They pause a timer before reading its counter, so every expected count follows from the exact number of bus-clock edges between the enable write and the disable write. The same-cycle event and clear case is lined up by placing the status clear directly after the enable write, so that the registered compare pulse meets the clear edge.

// File: rtl/tct_pkg.sv
package tct_pkg;
  // per-timer register slot, from address bits [3:2]
  localparam logic [1:0] SLOT_COUNT = 2'd0;
  localparam logic [1:0] SLOT_LOAD  = 2'd1;
  localparam logic [1:0] SLOT_CMP1  = 2'd2;
  localparam logic [1:0] SLOT_CMP2  = 2'd3;
  // shared register slot within the shared bank
  localparam logic [1:0] SHR_CTRL   = 2'd0;
  localparam logic [1:0] SHR_STAT   = 2'd1;
  localparam logic [1:0] SHR_MASK   = 2'd2;
  // event bit positions within a timer's 3-bit group
  localparam int EV_CMP1 = 0;
  localparam int EV_CMP2 = 1;
  localparam int EV_OVF  = 2;
  // control bit positions within a timer's 3-bit group
  localparam int CF_EN  = 0;
  localparam int CF_SEL = 1;
  localparam int CF_IE  = 2;
endpackage

// File: rtl/tct_tick_sync.sv
module tct_tick_sync (
  input  logic clk,
  input  logic rst,
  input  logic tick_async,
  output logic tick_rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tick_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tick_rise = s2_q & ~s3_q;

  // R10: a rising edge yields a single-cycle step pulse
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    tick_rise |=> !tick_rise);
endmodule

// File: rtl/tct_channel.sv
module tct_channel
  import tct_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic          step,
  input  logic          down,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cmp1_o,
  output logic [DW-1:0] cmp2_o,
  output logic [2:0]    ev_o
);
  logic          at_end;
  logic [DW-1:0] nxt;
  logic          wr_count;

  assign wr_count = wr_en && (wr_slot == SLOT_COUNT);

  always_comb begin
    at_end = down ? (count_o == '0) : (count_o == '1);
    if (at_end)   nxt = load_o;
    else if (down) nxt = count_o - 1'b1;
    else          nxt = count_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      load_o  <= '0;
      cmp1_o  <= '0;
      cmp2_o  <= '0;
      ev_o    <= '0;
    end else begin
      ev_o <= '0;
      if (wr_count) begin
        count_o <= wr_data;
      end else if (step) begin
        count_o        <= nxt;
        ev_o[EV_OVF]   <= at_end;
        ev_o[EV_CMP1]  <= (nxt == cmp1_o);
        ev_o[EV_CMP2]  <= (nxt == cmp2_o);
      end
      if (wr_en && wr_slot == SLOT_LOAD) load_o <= wr_data;
      if (wr_en && wr_slot == SLOT_CMP1) cmp1_o <= wr_data;
      if (wr_en && wr_slot == SLOT_CMP2) cmp2_o <= wr_data;
    end
  end

  // R3: no step and no counter write keeps the count
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr_count) |=> $stable(count_o));
  // R4: an up step away from the end value adds one
  p_up_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_count && !down && count_o != '1) |=> (count_o == $past(count_o) + 1'b1));
  // R5: an up step from all-ones reloads and flags overflow
  p_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_count && !down && count_o == '1) |=> (count_o == $past(load_o) && ev_o[EV_OVF]));
  // R6: a down step from zero reloads and flags overflow
  p_wrap_down_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_count && down && count_o == '0) |=> (count_o == $past(load_o) && ev_o[EV_OVF]));
endmodule

// File: rtl/tri_cmp_timer.sv
module tri_cmp_timer
  import tct_pkg::*;
#(
  parameter int N_TMR  = 3,
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic              ext_tick,
  output logic [N_TMR-1:0]  irq
);
  localparam int BANK_W = ADDR_W - 4;
  localparam int ST_W   = 3 * N_TMR;
  localparam int CTRL_W = 4 * N_TMR;

  logic [BANK_W-1:0] bank;
  logic [1:0]        slot;
  logic              aligned, wr, shr_sel, clr_wr;
  logic              ext_rise;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ST_W-1:0]   status_q, mask_q, ev_all, clr_bits;
  logic [N_TMR-1:0]  step, down, ch_wr;
  logic [DW-1:0]     ch_word [N_TMR][4];

  assign bank    = paddr[ADDR_W-1:4];
  assign slot    = paddr[3:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr      = psel && penable && pwrite && aligned;
  assign shr_sel = (bank == BANK_W'(N_TMR));
  assign clr_wr  = wr && shr_sel && (slot == SHR_STAT);
  assign clr_bits = clr_wr ? pwdata[ST_W-1:0] : '0;

  tct_tick_sync u_sync (
    .clk       (clk),
    .rst       (rst),
    .tick_async(ext_tick),
    .tick_rise (ext_rise)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign ch_wr[g] = wr && (bank == BANK_W'(g));
    assign step[g]  = ctrl_q[3*g+CF_EN] & (ctrl_q[3*g+CF_SEL] ? ext_rise : 1'b1);
    assign down[g]  = ctrl_q[3*N_TMR+g];

    tct_channel #(.DW(DW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (ch_wr[g]),
      .wr_slot(slot),
      .wr_data(pwdata),
      .step   (step[g]),
      .down   (down[g]),
      .count_o(ch_word[g][0]),
      .load_o (ch_word[g][1]),
      .cmp1_o (ch_word[g][2]),
      .cmp2_o (ch_word[g][3]),
      .ev_o   (ev_all[3*g +: 3])
    );

    // R9: interrupt enable clear forces the line low next cycle
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
      !ctrl_q[3*g+CF_IE] |=> !irq[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr && shr_sel && slot == SHR_CTRL) ctrl_q <= pwdata[CTRL_W-1:0];
      if (wr && shr_sel && slot == SHR_MASK) mask_q <= pwdata[ST_W-1:0];
      status_q <= (status_q & ~clr_bits) | ev_all;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= '0;
    end else begin
      for (int i = 0; i < N_TMR; i++)
        irq[i] <= ctrl_q[3*i+CF_IE] & (|(status_q[3*i +: 3] & ~mask_q[3*i +: 3]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata <= '0;
    end else if (psel && !penable) begin
      prdata <= '0;
      if (aligned) begin
        for (int i = 0; i < N_TMR; i++)
          if (bank == BANK_W'(i)) prdata <= ch_word[i][slot];
        if (shr_sel) begin
          case (slot)
            SHR_CTRL: prdata <= DW'(ctrl_q);
            SHR_STAT: prdata <= DW'(status_q);
            SHR_MASK: prdata <= DW'(mask_q);
            default:  prdata <= '0;
          endcase
        end
      end
    end
  end

  // R8: without a clear write no status bit drops
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R7: a recorded event is visible in status one cycle later
  p_event_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_all != '0) |=> ((status_q & $past(ev_all)) == $past(ev_all)));
endmodule

// File: tb/tri_cmp_timer_bench.sv
`timescale 1ns/1ps
module tri_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        ext_tick = 1'b0;
  logic [2:0]  irq;
  logic        chk_stb = 1'b0;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  tri_cmp_timer u_tri_cmp_timer (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_tick(ext_tick), .irq(irq)
  );

  // monitor: pops one expected item per read access cycle
  always @(negedge clk) begin
    if (chk_stb) begin
      exp_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (prdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, prdata, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(posedge clk); #1;
    penable = 1'b1; chk_stb = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; chk_stb = 1'b0;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string tag);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, irq, e);
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd(8'h30, 32'h0, "R1 ctrl");
    rd(8'h34, 32'h0, "R1 status");
    rd(8'h38, 32'h0, "R1 mask");
    rd(8'h00, 32'h0, "R1 count1");
    rd(8'h2C, 32'h0, "R1 cmp2 of timer3");
    chk_irq(3'b000, "R1 irq");
    // R2 register map
    wr(8'h14, 32'h1234_5678);
    wr(8'h18, 32'hA5A5_0001);
    wr(8'h1C, 32'h0F0F_F0F0);
    wr(8'h38, 32'h0000_0155);
    rd(8'h14, 32'h1234_5678, "R2 load2");
    rd(8'h18, 32'hA5A5_0001, "R2 cmp1 of timer2");
    rd(8'h1C, 32'h0F0F_F0F0, "R2 cmp2 of timer2");
    rd(8'h38, 32'h0000_0155, "R2 mask");
    rd(8'h04, 32'h0, "R2 load1 untouched");
    wr(8'h38, 32'h0);
    // R3 direct write and hold while disabled
    wr(8'h00, 32'd5);
    idle(10);
    rd(8'h00, 32'd5, "R3 hold count1");
    // R4 up on bus clock: 10 idle + 2 edges of the disable write
    wr(8'h00, 32'd100);
    wr(8'h30, 32'h001);
    idle(10);
    wr(8'h30, 32'h000);
    rd(8'h00, 32'd112, "R4 up count");
    // R6 down with underflow reload
    wr(8'h08, 32'hFFFF_0000);
    wr(8'h0C, 32'hFFFF_0000);
    wr(8'h04, 32'd50);
    wr(8'h00, 32'd2);
    wr(8'h30, 32'h201);
    idle(3);
    wr(8'h30, 32'h200);
    rd(8'h00, 32'd48, "R6 down count after reload");
    rd(8'h34, 32'h004, "R6 overflow status timer1");
    // R5 periodic, P=4, 8 steps
    wr(8'h30, 32'h000);
    wr(8'h10, 32'hFFFF_FFFC);
    wr(8'h14, 32'hFFFF_FFFC);
    wr(8'h30, 32'h008);
    idle(6);
    wr(8'h30, 32'h000);
    rd(8'h10, 32'hFFFF_FFFC, "R5 periodic count2");
    rd(8'h34, 32'h024, "R5 overflow status timer2");
    // R8 partial clear
    wr(8'h34, 32'h004);
    rd(8'h34, 32'h020, "R8 partial clear");
    wr(8'h34, 32'h020);
    rd(8'h34, 32'h000, "R8 full clear");
    // R7 / R9 compare events on timer3
    wr(8'h28, 32'd10);
    wr(8'h2C, 32'd20);
    wr(8'h20, 32'd0);
    wr(8'h30, 32'h140);
    idle(20);
    wr(8'h30, 32'h100);
    rd(8'h20, 32'd22, "R7 count3");
    rd(8'h34, 32'h0C0, "R7 compare status timer3");
    chk_irq(3'b100, "R9 irq timer3 raised");
    wr(8'h38, 32'h0C0);
    rd(8'h34, 32'h0C0, "R9 status unchanged by mask");
    chk_irq(3'b000, "R9 irq masked");
    wr(8'h38, 32'h000);
    idle(2);
    chk_irq(3'b100, "R9 irq unmasked");
    wr(8'h30, 32'h000);
    idle(2);
    chk_irq(3'b000, "R9 irq enable cleared");
    wr(8'h34, 32'h1FF);
    // R8 event and clear in the same cycle
    wr(8'h2C, 32'hFFFF_0000);
    wr(8'h28, 32'd1);
    wr(8'h20, 32'd0);
    wr(8'h30, 32'h040);
    wr(8'h34, 32'h040);
    wr(8'h30, 32'h000);
    rd(8'h34, 32'h040, "R8 event wins over clear");
    wr(8'h34, 32'h1FF);
    // R10 external tick, timer1 up
    wr(8'h00, 32'd0);
    wr(8'h30, 32'h003);
    idle(8);
    for (int k = 0; k < 5; k++) begin
      ext_tick = 1'b1; idle(3);
      ext_tick = 1'b0; idle(3);
    end
    idle(10);
    wr(8'h30, 32'h000);
    rd(8'h00, 32'd5, "R10 external tick count");
    rd(8'h34, 32'h000, "R10 no events");
    idle(2);
    finish_run();
  end
endmodule